// File: doc/BRIEF.md
# Program Memory Password Lock

This block decides whether the privileged utility paths of a small microcontroller (debug access, in-system programming and in-application programming) may be used. A password of sixteen 16-bit words lives in program memory at word addresses 0x0010 to 0x001F. After reset the block walks that region through a synchronous read port and notes whether it is blank. Blank means every word is 0xFFFF, or every word is 0x0000. Software or a debug host then presents a candidate password one word at a time over a valid/ready input. The block compares each word with the stored word at the same position.

A lock bit decides whether the password matters at all. When the lock is clear, or the stored region is blank, the grant output rises as soon as the region scan ends. Otherwise the grant stays low until a full candidate of sixteen matching words has been received. A mass-erase pulse means the region now holds all ones. The block takes that as the new stored contents at once and grants access.

Top module: `pm_pw_guard`

## Requirements
- R1: `lock_bit` is 1 from reset. A cycle with `lock_wr_en` high loads `lock_wr_data` into it, and the new value is visible on `lock_bit` from the next cycle.
- R2: After reset the block issues exactly one read per cycle at addresses 0x0010, 0x0011, ... 0x001F, in that order. The read data returns one cycle after each request. `cand_ready` and `access_ok` stay low until the last word has been evaluated, and `cand_ready` is first high 17 cycles after reset release.
- R3: With `lock_bit` at 0 and the scan complete, `access_ok` is 1 whatever the stored region holds.
- R4: With `lock_bit` at 1 and all sixteen stored words equal to 0xFFFF, `access_ok` is 1 after the scan with no candidate supplied.
- R5: With `lock_bit` at 1 and all sixteen stored words equal to 0x0000, `access_ok` is 1 after the scan with no candidate supplied.
- R6: With `lock_bit` at 1 and any other stored contents, `access_ok` is 0 until sixteen candidate words are accepted that each equal the stored word at the same position, in address order. It is 1 from the cycle after the compare of the sixteenth word.
- R7: A candidate in which any one of the sixteen words differs leaves `access_ok` at 0. After the sixteenth word the word position returns to the first address, so the next sixteen words form a fresh attempt.
- R8: A write that changes `lock_bit` from 0 to 1 withdraws any earlier password match. `access_ok` is then 0 unless the stored region is blank.
- R9: A cycle with `mass_erase` high makes the stored region count as all ones. `access_ok` is 1 from the next cycle, and any partly received candidate is discarded.
- R10: After each accepted candidate word, `cand_ready` is low for exactly the next cycle while that word is compared.
- R11: A completed failing attempt made after a successful one withdraws the grant when the lock is set and the region is not blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_en | output | 1 | Program memory read request |
| mem_rd_addr | output | 16 | Program memory word address |
| mem_rd_data | input | 16 | Read data, valid the cycle after the request |
| cand_valid | input | 1 | Candidate word valid |
| cand_ready | output | 1 | Candidate word can be accepted |
| cand_data | input | 16 | Candidate password word |
| lock_wr_en | input | 1 | Write strobe for the lock bit |
| lock_wr_data | input | 1 | Value written to the lock bit |
| lock_bit | output | 1 | Current lock bit |
| mass_erase | input | 1 | Single-cycle pulse: program memory was mass erased |
| access_ok | output | 1 | Privileged utility functions allowed |

## Verification
A blank flag that was folded wrongly during the scan shows up at the first sample after the scan ends: `access_ok` is high for a protected region, or low for an erased or zeroed one. A word position counter that is out of step causes a correct candidate to be rejected within 33 cycles of its first word. The read addresses recorded during the scan also expose the fault in cycle order. A match flag that is not cleared by a lock rise, or kept across a failing attempt, leaves `access_ok` high in the cycle after the write or compare that should have withdrawn it.

// File: rtl/pm_pw_pkg.sv
package pm_pw_pkg;

   // Phase of the candidate comparator: accepting a word or checking it
   typedef enum logic {
      MT_TAKE  = 1'b0,
      MT_CHECK = 1'b1
   } match_state_e;

   // Width of an index that counts 0 .. n-1, never zero bits
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pm_pw_scan.sv
module pm_pw_scan #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned N      = 16,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BASE   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic              scan_done,
   output logic              all_ones,
   output logic              all_zeros
);
   localparam int unsigned CNT_W = $clog2(N + 1);

   logic [CNT_W-1:0] issue_cnt;
   logic             rv_q;
   logic             last_q;
   logic             done_q;
   logic             ones_q;
   logic             zeros_q;

   assign rd_en   = !done_q && (issue_cnt < CNT_W'(N)) && !erase;
   assign rd_addr = ADDR_W'(BASE) + ADDR_W'(issue_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue_cnt <= '0;
         rv_q      <= 1'b0;
         last_q    <= 1'b0;
         done_q    <= 1'b0;
         ones_q    <= 1'b1;
         zeros_q   <= 1'b1;
      end else if (erase) begin
         issue_cnt <= CNT_W'(N);
         rv_q      <= 1'b0;
         last_q    <= 1'b0;
         done_q    <= 1'b1;
         ones_q    <= 1'b1;
         zeros_q   <= 1'b0;
      end else begin
         rv_q   <= rd_en;
         last_q <= rd_en && (issue_cnt == CNT_W'(N - 1));
         if (rd_en) begin
            issue_cnt <= issue_cnt + 1'b1;
         end
         if (rv_q) begin
            ones_q  <= ones_q  && (rd_data == {WORD_W{1'b1}});
            zeros_q <= zeros_q && (rd_data == {WORD_W{1'b0}});
         end
         if (rv_q && last_q) begin
            done_q <= 1'b1;
         end
      end
   end

   assign scan_done = done_q;
   assign all_ones  = ones_q;
   assign all_zeros = zeros_q;

endmodule

// File: rtl/pm_pw_match.sv
module pm_pw_match
   import pm_pw_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned N      = 16,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BASE   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_done,
   input  logic              erase,
   input  logic              lock_arm,
   input  logic              cand_valid,
   input  logic [WORD_W-1:0] cand_data,
   output logic              cand_ready,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic              matched
);
   localparam int unsigned IDX_W = idx_width(N);

   match_state_e      st_q;
   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  pos_q;
   logic              bad_q;
   logic              match_q;
   logic              take;
   logic              differs;

   assign cand_ready = scan_done && (st_q == MT_TAKE) && !erase;
   assign take       = cand_valid && cand_ready;
   assign rd_en      = take;
   assign rd_addr    = ADDR_W'(BASE) + ADDR_W'(pos_q);
   assign differs    = (rd_data != word_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= MT_TAKE;
         word_q  <= '0;
         pos_q   <= '0;
         bad_q   <= 1'b0;
         match_q <= 1'b0;
      end else if (erase) begin
         st_q    <= MT_TAKE;
         pos_q   <= '0;
         bad_q   <= 1'b0;
         match_q <= 1'b0;
      end else begin
         case (st_q)
            MT_TAKE: begin
               if (take) begin
                  word_q <= cand_data;
                  st_q   <= MT_CHECK;
               end
            end
            MT_CHECK: begin
               st_q <= MT_TAKE;
               if (pos_q == IDX_W'(N - 1)) begin
                  match_q <= !(bad_q || differs);
                  pos_q   <= '0;
                  bad_q   <= 1'b0;
               end else begin
                  pos_q <= pos_q + 1'b1;
                  bad_q <= bad_q || differs;
               end
            end
            default: st_q <= MT_TAKE;
         endcase
         if (lock_arm) begin
            match_q <= 1'b0;
         end
      end
   end

   assign matched = match_q;

endmodule

// File: rtl/pm_pw_lockreg.sv
module pm_pw_lockreg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_data,
   output logic lock,
   output logic arm
);
   logic lock_q;

   assign arm = wr_en && wr_data && !lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b1;
      end else if (wr_en) begin
         lock_q <= wr_data;
      end
   end

   assign lock = lock_q;

endmodule

// File: rtl/pm_pw_guard.sv
module pm_pw_guard #(
   parameter int unsigned WORD_W        = 16,
   parameter int unsigned PW_WORDS      = 16,
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned BASE          = 16,
   parameter bit          ZERO_IS_BLANK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [WORD_W-1:0] mem_rd_data,
   input  logic              cand_valid,
   output logic              cand_ready,
   input  logic [WORD_W-1:0] cand_data,
   input  logic              lock_wr_en,
   input  logic              lock_wr_data,
   output logic              lock_bit,
   input  logic              mass_erase,
   output logic              access_ok
);
   // Elaboration-time parameter checks
   if (WORD_W < 2) begin : g_bad_word_w
      $error("pm_pw_guard: WORD_W must be at least 2");
   end
   if (PW_WORDS < 1) begin : g_bad_words
      $error("pm_pw_guard: PW_WORDS must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr_w
      $error("pm_pw_guard: ADDR_W out of range");
   end
   if ((BASE + PW_WORDS) > (1 << ADDR_W)) begin : g_bad_window
      $error("pm_pw_guard: password window exceeds address space");
   end

   logic              scan_done;
   logic              all_ones;
   logic              all_zeros;
   logic              blank;
   logic              scan_rd_en;
   logic [ADDR_W-1:0] scan_rd_addr;
   logic              cmp_rd_en;
   logic [ADDR_W-1:0] cmp_rd_addr;
   logic              matched;
   logic              lock_arm;

   pm_pw_lockreg u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lock_wr_en),
      .wr_data (lock_wr_data),
      .lock    (lock_bit),
      .arm     (lock_arm)
   );

   pm_pw_scan #(
      .WORD_W (WORD_W),
      .N      (PW_WORDS),
      .ADDR_W (ADDR_W),
      .BASE   (BASE)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase     (mass_erase),
      .rd_en     (scan_rd_en),
      .rd_addr   (scan_rd_addr),
      .rd_data   (mem_rd_data),
      .scan_done (scan_done),
      .all_ones  (all_ones),
      .all_zeros (all_zeros)
   );

   pm_pw_match #(
      .WORD_W (WORD_W),
      .N      (PW_WORDS),
      .ADDR_W (ADDR_W),
      .BASE   (BASE)
   ) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_done  (scan_done),
      .erase      (mass_erase),
      .lock_arm   (lock_arm),
      .cand_valid (cand_valid),
      .cand_data  (cand_data),
      .cand_ready (cand_ready),
      .rd_en      (cmp_rd_en),
      .rd_addr    (cmp_rd_addr),
      .rd_data    (mem_rd_data),
      .matched    (matched)
   );

   // The scan owns the port before scan_done, the comparator after it
   assign mem_rd_en   = scan_rd_en || cmp_rd_en;
   assign mem_rd_addr = scan_rd_en ? scan_rd_addr : cmp_rd_addr;

   generate
      if (ZERO_IS_BLANK) begin : g_blank_both
         assign blank = all_ones || all_zeros;
      end else begin : g_blank_ones
         logic unused_zeros;
         assign unused_zeros = all_zeros;
         assign blank        = all_ones;
      end
   endgenerate

   assign access_ok = scan_done && (!lock_bit || blank || matched);

endmodule

// File: rtl/pm_pw_guard_chk.sv
module pm_pw_guard_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BASE   = 16,
   parameter int unsigned N      = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              cand_valid,
   input logic              cand_ready,
   input logic              mass_erase,
   input logic              access_ok,
   input logic              lock_bit,
   input logic              scan_done,
   input logic              blank
);
   localparam logic [ADDR_W:0] LO = (ADDR_W + 1)'(BASE);
   localparam logic [ADDR_W:0] HI = (ADDR_W + 1)'(BASE + N);

   // R2: nothing is offered or granted before the region scan ends
   p_quiet_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_done |-> (!cand_ready && !access_ok));

   // R2: reads stay inside the password window
   p_addr_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (({1'b0, mem_rd_addr} >= LO) && ({1'b0, mem_rd_addr} < HI)));

   // R8: arming the lock withdraws a match on a non-blank region
   p_arm_revokes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lock_bit) && !blank) |-> !access_ok);

   // R9: erase grants from the next cycle
   p_erase_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mass_erase |=> access_ok);

   // R10: a compare cycle follows every accepted word
   p_word_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && cand_ready) |=> !cand_ready);

endmodule

bind pm_pw_guard pm_pw_guard_chk #(
   .ADDR_W (ADDR_W),
   .BASE   (BASE),
   .N      (PW_WORDS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_addr (mem_rd_addr),
   .cand_valid  (cand_valid),
   .cand_ready  (cand_ready),
   .mass_erase  (mass_erase),
   .access_ok   (access_ok),
   .lock_bit    (lock_bit),
   .scan_done   (scan_done),
   .blank       (blank)
);

// File: tb/pm_pw_guard_tb_top.sv
`timescale 1ns/1ps
module pm_pw_guard_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_rd_en;
   logic [15:0] mem_rd_addr;
   logic [15:0] mem_rd_data = '0;
   logic        cand_valid = 1'b0;
   logic        cand_ready;
   logic [15:0] cand_data = '0;
   logic        lock_wr_en = 1'b0;
   logic        lock_wr_data = 1'b0;
   logic        lock_bit;
   logic        mass_erase = 1'b0;
   logic        access_ok;

   logic [15:0] mem [0:63];
   logic [15:0] log_addr [0:15];
   int          log_n;
   int          n_chk = 0;
   int          n_err = 0;
   bit          m_lock;
   bit          m_match;
   bit          finished = 0;

   always #2.5 clk = ~clk;

   pm_pw_guard dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .mem_rd_en    (mem_rd_en),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_data  (mem_rd_data),
      .cand_valid   (cand_valid),
      .cand_ready   (cand_ready),
      .cand_data    (cand_data),
      .lock_wr_en   (lock_wr_en),
      .lock_wr_data (lock_wr_data),
      .lock_bit     (lock_bit),
      .mass_erase   (mass_erase),
      .access_ok    (access_ok)
   );

   // Program memory model with one cycle read latency
   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[5:0]];
   end

   // Records the first sixteen read addresses after each reset
   always @(posedge clk) begin
      if (!rst_n) begin
         log_n <= 0;
      end else if (mem_rd_en && log_n < 16) begin
         log_addr[log_n] <= mem_rd_addr;
         log_n <= log_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit region_blank();
      bit ones = 1, zeros = 1;
      for (int i = 0; i < 16; i++) begin
         if (mem[16 + i] != 16'hFFFF) ones = 0;
         if (mem[16 + i] != 16'h0000) zeros = 0;
      end
      return ones || zeros;
   endfunction

   function automatic bit exp_grant();
      return !m_lock || region_blank() || m_match;
   endfunction

   task automatic fill_random();
      for (int i = 0; i < 16; i++) mem[16 + i] = 16'($urandom);
      mem[16] = 16'h5A5A;
   endtask

   task automatic fill_const(input logic [15:0] v);
      for (int i = 0; i < 16; i++) mem[16 + i] = v;
   endtask

   // Reset, check the reset state and the scan timing and order
   task automatic do_reset(input bit detail);
      int cyc = 0;
      rst_n = 1'b0; cand_valid = 0; lock_wr_en = 0; mass_erase = 0;
      m_lock = 1; m_match = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      if (detail) begin
         chk("R1 lock after reset", lock_bit, 1);
         chk("R2 no grant before scan", access_ok, 0);
         chk("R2 no ready before scan", cand_ready, 0);
      end
      while (!cand_ready && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      if (detail) begin
         chk("R2 scan length", cyc, 17);
         for (int i = 0; i < 16; i++) chk("R2 scan order", log_addr[i], 16'h0010 + i);
      end
   endtask

   task automatic send_word(input logic [15:0] w);
      int guard = 0;
      while (!cand_ready && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      cand_valid = 1'b1;
      cand_data  = w;
      @(negedge clk);
      cand_valid = 1'b0;
      chk("R10 ready low in compare cycle", cand_ready, 0);
   endtask

   task automatic attempt(input bit corrupt);
      int          pos  = $urandom_range(0, 15);
      logic [15:0] flip = 16'h0001 << $urandom_range(0, 15);
      for (int i = 0; i < 16; i++)
         send_word((corrupt && i == pos) ? (mem[16 + i] ^ flip) : mem[16 + i]);
      @(negedge clk);
      m_match = !corrupt;
   endtask

   task automatic write_lock(input bit v);
      lock_wr_en = 1'b1; lock_wr_data = v;
      @(negedge clk);
      lock_wr_en = 1'b0;
      if (v && !m_lock) m_match = 0;
      m_lock = v;
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 64; i++) mem[i] = 16'(i * 7);

      // Protected region: denial, wrong and right attempts (R1 R2 R6 R7 R11)
      fill_random();
      do_reset(1);
      chk("R6 denied after scan", access_ok, exp_grant());
      attempt(1);
      chk("R7 one bad word denied", access_ok, 0);
      attempt(0);
      chk("R6 correct password grants", access_ok, 1);
      attempt(1);
      chk("R11 failing attempt revokes", access_ok, 0);
      attempt(0);
      chk("R7 fresh attempt after failure", access_ok, 1);

      // Lock bit writes (R1 R3 R8)
      write_lock(0);
      chk("R1 lock written to 0", lock_bit, 0);
      chk("R3 unlocked grants", access_ok, 1);
      write_lock(1);
      chk("R8 arming withdraws match", access_ok, 0);
      write_lock(0);
      chk("R3 unlocked again", access_ok, 1);
      write_lock(1);
      chk("R1 lock written to 1", lock_bit, 1);

      // Mass erase in the middle of an attempt (R9)
      for (int i = 0; i < 7; i++) send_word(mem[16 + i]);
      mass_erase = 1'b1;
      fill_const(16'hFFFF);
      @(negedge clk);
      mass_erase = 1'b0;
      m_match = 0;
      chk("R9 erase grants next cycle", access_ok, 1);
      attempt(1);
      chk("R4 erased region stays open", access_ok, 1);

      // Blank and near-blank regions (R3 R4 R5 R6)
      fill_const(16'hFFFF);
      do_reset(0);
      chk("R4 all ones grants", access_ok, 1);
      fill_const(16'h0000);
      do_reset(0);
      chk("R5 all zeros grants", access_ok, 1);
      mem[16 + 9] = 16'h0001;
      do_reset(0);
      chk("R6 near-zero region denied", access_ok, 0);
      write_lock(0);
      chk("R3 unlock overrides content", access_ok, 1);
      fill_const(16'hFFFF);
      mem[16 + 15] = 16'hFFFE;
      do_reset(0);
      chk("R6 near-ones region denied", access_ok, 0);

      // Random regions and attempts against the model
      for (int t = 0; t < 20; t++) begin
         fill_random();
         do_reset(t < 2);
         chk("R6 random region denied", access_ok, exp_grant());
         for (int a = 0; a < 3; a++) begin
            attempt($urandom_range(0, 1) == 1);
            chk("R6 R7 random attempt", access_ok, exp_grant());
            if ($urandom_range(0, 3) == 0) begin
               write_lock(!m_lock);
               chk("R8 random lock write", access_ok, exp_grant());
            end
         end
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule